// File: doc/BRIEF.md
# SM4 Round-Key Expander and Key Store

This block turns a 128-bit cipher key into the 32 round keys of the SM4 block cipher and keeps them in a small register file for the data-path core. A single combinational round stage is reused once per clock. Its state register is reloaded from the key, and after that it feeds back on itself. One round key is produced and written on each of 32 consecutive cycles. Expansion runs once per message. Every block of that message then reads the same stored keys.

The cipher core presents its 5-bit round number and a direction bit, and receives the matching 32-bit round key combinationally on the same cycle. Encryption reads entry `idx`. Decryption reads entry `~idx`, which is entry `31 - idx`, so the reversed key order costs only an inverter row.

The key input is a plain strobe with no back-pressure. A start pulse is always accepted, even in the middle of an expansion, and it restarts the work from the first round with the key present on that cycle. The `ready_o` status is the only flow control. The cipher core must not begin a block while it is low. It is low whenever the store may hold keys from a previous key or a mix of two keys.

Top module: `sm4_key_sched`

## Requirements
- R1: On an accepted start, the working state (k0,k1,k2,k3) is loaded with `key_i` XOR the system constant A3B1BAC6_56AA3350_677D9197_B27022DC. Word k0 is bits 127:96.
- R2: Each round i computes k[i+4] = k[i] XOR T'(k[i+1] XOR k[i+2] XOR k[i+3] XOR ck[i]). That value is round key i and is written to store entry i.
- R3: T' applies the SM4 S-box to each byte and then x ^ (x<<<13) ^ (x<<<23). The S-box is computed at elaboration from field inversion modulo x^8+x^7+x^6+x^5+x^4+x^2+1, wrapped in the affine map with row mask 0xA7 and constant 0xD3.
- R4: Byte j of ck[i] (j=0 the most significant byte) equals ((4i+j)*7) mod 256.
- R5: Rounds 0..31 are computed on the 32 clock edges that follow the accepting edge, one per edge. `ready_o` rises right after the edge that writes entry 31. For key 0123456789ABCDEFFEDCBA9876543210, entry 0 holds F12186F9 and entry 31 holds 9124A012.
- R6: With `dec_i`=0, `rk_o` is store entry `rnd_idx_i`. With `dec_i`=1, it is entry `~rnd_idx_i`. The read is combinational.
- R7: `ready_o` is low in every cycle where `start_i` is high, and it stays low until the expansion that start begins has written entry 31.
- R8: A start during an expansion discards the work in progress and restarts from round 0 with the new key. Ready then rises 32 edges after the latest accepting edge.
- R9: Without a start, `ready_o` stays high and the stored keys do not change. Changes on `key_i` then have no effect on `rk_o`.
- R10: While reset is asserted and after it is released, `ready_o` is low until a first expansion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; accepted on every rising edge where it is high |
| key_i | input | 128 | Cipher key, sampled on the accepting edge |
| dec_i | input | 1 | 1 selects reverse (decryption) key order |
| rnd_idx_i | input | IDX_W (5) | Round number from the cipher core, 0 for the first round |
| rk_o | output | 32 | Selected round key |
| ready_o | output | 1 | All 32 stored keys belong to the last accepted key |

## Verification
Key values are tried with the standard test key. Its first and last round keys are fixed, so together they separate a wrong system constant, round constant, S-box or linear map. The full table read in both directions tells a correct index inversion from one that is off by one or not applied. A run that restarts from an all-zero key partway through, and then a start held over several cycles, distinguish a true restart from a counter that keeps running. A burst of reads with the key input changing and no strobe shows that the store and ready only move on a start.

// File: rtl/sm4kx_pkg.sv
package sm4kx_pkg;

  localparam int WORD_W = 32;
  localparam int STATE_W = 4 * WORD_W;
  localparam logic [STATE_W-1:0] SYS_PARAM = 128'hA3B1BAC6_56AA3350_677D9197_B27022DC;
  localparam logic [7:0] FIELD_POLY_LO = 8'hF5;   // x^8 + x^7+x^6+x^5+x^4+x^2+1
  localparam logic [7:0] AFF_ROW = 8'hA7;
  localparam logic [7:0] AFF_CONST = 8'hD3;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[7] ? ({sh[6:0], 1'b0} ^ FIELD_POLY_LO) : {sh[6:0], 1'b0};
    end
    return acc;
  endfunction

  // x^254 by square and multiply; maps zero to zero.
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] p;
    logic [7:0] r;
    p = gf_mul(x, x);
    r = 8'h01;
    for (int k = 1; k < 8; k++) begin
      r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] m, input logic [2:0] n);
    logic [15:0] d;
    d = {m, m} << n;
    return d[15:8];
  endfunction

  function automatic logic [7:0] affine(input logic [7:0] x);
    logic [7:0] y;
    for (int i = 0; i < 8; i++) y[i] = ^(x & rotl8(AFF_ROW, 3'(i)));
    return y ^ AFF_CONST;
  endfunction

  function automatic logic [7:0] sbox_calc(input logic [7:0] x);
    return affine(gf_inv(affine(x)));
  endfunction

  function automatic logic [2047:0] build_sbox();
    logic [2047:0] t;
    for (int v = 0; v < 256; v++) t[v*8 +: 8] = sbox_calc(8'(v));
    return t;
  endfunction

  localparam logic [2047:0] SBOX_ROM = build_sbox();

  function automatic logic [WORD_W-1:0] rotl32(input logic [WORD_W-1:0] x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic logic [WORD_W-1:0] key_lin(input logic [WORD_W-1:0] x);
    return x ^ rotl32(x, 13) ^ rotl32(x, 23);
  endfunction

  // Round constant: byte j (0 = most significant) = ((4i+j)*7) mod 256.
  function automatic logic [WORD_W-1:0] round_const(input int i);
    logic [WORD_W-1:0] w;
    for (int j = 0; j < 4; j++) w[WORD_W-1-8*j -: 8] = 8'(((4 * i + j) * 7) & 255);
    return w;
  endfunction

endpackage

// File: rtl/sm4kx_sbox4.sv
module sm4kx_sbox4
  import sm4kx_pkg::*;
(
  input  logic [WORD_W-1:0] a_i,
  output logic [WORD_W-1:0] s_o
);
  localparam int LANES = WORD_W / 8;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [10:0] base;
    assign base = {a_i[8*g +: 8], 3'b000};
    assign s_o[8*g +: 8] = SBOX_ROM[base +: 8];
  end
endmodule

// File: rtl/sm4kx_round.sv
module sm4kx_round
  import sm4kx_pkg::*;
(
  input  logic [STATE_W-1:0] st_i,
  input  logic [WORD_W-1:0]  ck_i,
  output logic [WORD_W-1:0]  nw_o
);
  logic [WORD_W-1:0] mix;
  logic [WORD_W-1:0] sub;

  assign mix = st_i[3*WORD_W-1 -: WORD_W] ^ st_i[2*WORD_W-1 -: WORD_W]
             ^ st_i[WORD_W-1:0] ^ ck_i;

  sm4kx_sbox4 u_sbox (
    .a_i(mix),
    .s_o(sub)
  );

  assign nw_o = st_i[STATE_W-1 -: WORD_W] ^ key_lin(sub);
endmodule

// File: rtl/sm4kx_seq.sv
module sm4kx_seq #(
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] cnt_o,
  output logic             valid_o
);
  localparam logic [IDX_W-1:0] LAST = '1;

  logic             busy_q;
  logic [IDX_W-1:0] cnt_q;
  logic             valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_q  <= 1'b0;
        valid_q <= 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign cnt_o   = cnt_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/sm4kx_keyfile.sv
module sm4kx_keyfile #(
  parameter int IDX_W  = 5,
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wa_i,
  input  logic [WORD_W-1:0] wd_i,
  input  logic              rev_i,
  input  logic [IDX_W-1:0]  ra_i,
  output logic [WORD_W-1:0] rd_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0]  addr;

  always_ff @(posedge clk_i) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (we_i && wa_i == IDX_W'(e)) mem_q[e] <= wd_i;
    end
  end

  // Reverse order is the one's complement of the index.
  assign addr = rev_i ? ~ra_i : ra_i;
  assign rd_o = mem_q[addr];
endmodule

// File: rtl/sm4_key_sched.sv
module sm4_key_sched
  import sm4kx_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [127:0]       key_i,
  input  logic               dec_i,
  input  logic [IDX_W-1:0]   rnd_idx_i,
  output logic [31:0]        rk_o,
  output logic               ready_o
);
  logic               busy;
  logic               valid;
  logic [IDX_W-1:0]   cnt;
  logic [STATE_W-1:0] state_q;
  logic [WORD_W-1:0]  ck;
  logic [WORD_W-1:0]  new_word;

  sm4kx_seq #(.IDX_W(IDX_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .busy_o (busy),
    .cnt_o  (cnt),
    .valid_o(valid)
  );

  assign ck = round_const(int'(cnt));

  sm4kx_round u_round (
    .st_i(state_q),
    .ck_i(ck),
    .nw_o(new_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= '0;
    else if (start_i) state_q <= key_i ^ SYS_PARAM;
    else if (busy)    state_q <= {state_q[STATE_W-WORD_W-1:0], new_word};
  end

  sm4kx_keyfile #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_keys (
    .clk_i(clk_i),
    .we_i (busy && !start_i),
    .wa_i (cnt),
    .wd_i (new_word),
    .rev_i(dec_i),
    .ra_i (rnd_idx_i),
    .rd_o (rk_o)
  );

  assign ready_o = valid && !start_i;
endmodule

// File: rtl/sm4_key_sched_chk.sv
module sm4_key_sched_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             dec_i,
  input logic [IDX_W-1:0] rnd_idx_i,
  input logic [31:0]      rk_o,
  input logic             ready_o
);
  localparam int CW = IDX_W + 2;
  localparam logic [CW-1:0] ROUNDS = CW'(1 << IDX_W);

  logic [CW-1:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               since_q <= '1;
    else if (start_i)          since_q <= '0;
    else if (since_q != '1)    since_q <= since_q + 1'b1;
  end

  a_r7_start_blocks_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !ready_o);

  a_r5_ready_after_all_rounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> since_q == ROUNDS);

  a_r9_ready_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> (ready_o || start_i));

  a_r9_keys_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && $past(ready_o) && $stable(rnd_idx_i) && $stable(dec_i)) |-> $stable(rk_o));

  a_r10_reset_not_ready: assert property (@(posedge clk_i)
    !rst_ni |=> !ready_o);
endmodule

bind sm4_key_sched sm4_key_sched_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .dec_i    (dec_i),
  .rnd_idx_i(rnd_idx_i),
  .rk_o     (rk_o),
  .ready_o  (ready_o)
);

// File: tb/sm4_key_sched_bench.sv
module sm4_key_sched_bench;
  localparam logic [127:0] STD_KEY = 128'h01234567_89ABCDEF_FEDCBA98_76543210;
  localparam logic [31:0]  STD_RK0 = 32'hF12186F9;
  localparam logic [31:0]  STD_RK31 = 32'h9124A012;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] key_i = '0;
  logic         dec_i = 1'b0;
  logic [4:0]   rnd_idx_i = '0;
  logic [31:0]  rk_o;
  logic         ready_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] tbl [32];

  // Behavioural model of the status: cycles left until the store is complete.
  bit m_valid = 1'b0;
  int m_left = 0;

  always #10 clk = ~clk;

  sm4_key_sched u_sm4_key_sched (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .key_i    (key_i),
    .dec_i    (dec_i),
    .rnd_idx_i(rnd_idx_i),
    .rk_o     (rk_o),
    .ready_o  (ready_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_valid = 1'b0;
      m_left = 0;
    end else if (start_i) begin
      m_valid = 1'b0;
      m_left = 32;
    end else if (m_left > 0) begin
      m_left = m_left - 1;
      if (m_left == 0) m_valid = 1'b1;
    end
  end

  // R5 R7 R8 R10: ready compared with the model on every clock
  always @(negedge clk) begin
    if (!done) begin
      bit exp_rdy;
      exp_rdy = m_valid && !start_i;
      check(ready_o === exp_rdy, "R5/R7 ready timing", 32'(ready_o), 32'(exp_rdy));
    end
  end

  task automatic kick(input logic [127:0] k, input int hold);
    @(posedge clk); #1;
    key_i = k;
    start_i = 1'b1;
    repeat (hold) @(posedge clk);
    #1 start_i = 1'b0;
  endtask

  task automatic rd(input bit d, input int i, output logic [31:0] v);
    @(posedge clk); #1;
    dec_i = d;
    rnd_idx_i = 5'(i);
    @(negedge clk);
    v = rk_o;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ready_o === 1'b0, "R10 ready in reset", 32'(ready_o), 32'd0);
    #1 rst_ni = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(ready_o === 1'b0, "R10 ready before first expansion", 32'(ready_o), 32'd0);

    // Standard key: R1 R2 R3 R4 through known first and last keys
    kick(STD_KEY, 1);
    repeat (34) @(posedge clk);
    for (int i = 0; i < 32; i++) begin
      rd(1'b0, i, v);
      tbl[i] = v;
    end
    check(tbl[0] === STD_RK0, "R1 R2 R3 R4 R5 first round key", tbl[0], STD_RK0);
    check(tbl[31] === STD_RK31, "R1 R2 R3 R4 R5 last round key", tbl[31], STD_RK31);

    // R6: reverse order reads entry 31-idx
    for (int i = 0; i < 32; i++) begin
      rd(1'b1, i, v);
      check(v === tbl[31-i], "R6 decrypt order", v, tbl[31-i]);
    end

    // R9: key input changes without a start have no effect
    @(posedge clk); #1 key_i = 128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555;
    repeat (5) @(posedge clk);
    for (int i = 0; i < 32; i += 5) begin
      rd(1'b0, i, v);
      check(v === tbl[i], "R9 keys kept without start", v, tbl[i]);
    end
    @(negedge clk);
    check(ready_o === 1'b1, "R9 ready held", 32'(ready_o), 32'd1);

    // R8: restart during expansion from a zero key to the standard key
    kick('0, 1);
    repeat (10) @(posedge clk);
    kick(STD_KEY, 1);
    repeat (12) @(posedge clk);
    @(negedge clk);
    check(ready_o === 1'b0, "R8 ready low after restart", 32'(ready_o), 32'd0);
    repeat (24) @(posedge clk);
    rd(1'b0, 0, v);
    check(v === STD_RK0, "R8 restart first key", v, STD_RK0);
    rd(1'b0, 31, v);
    check(v === STD_RK31, "R8 restart last key", v, STD_RK31);

    // R7: start held for several cycles, then a fresh expansion
    kick(STD_KEY, 3);
    repeat (34) @(posedge clk);
    rd(1'b1, 31, v);
    check(v === STD_RK0, "R7 R6 held start then reverse read", v, STD_RK0);
    rd(1'b1, 0, v);
    check(v === STD_RK31, "R7 R6 held start then reverse read", v, STD_RK31);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule